// File: doc/BRIEF.md
# Single-Wire Humidity and Temperature Sensor Reader

This block performs one complete measurement transaction with a combined humidity and temperature sensor that shares a single open-drain data line with the host. A one-cycle strobe on `start_i` begins the transaction. The block pulls the line low for a long wake-up interval. It then drives the line high for a short interval and releases it. From that point it times every line transition against a microsecond tick. The tick is derived from the system clock frequency parameter.

The sensor first answers with a fixed preamble. It then sends forty data bits. The length of each high phase carries one bit. The block shifts the bits into a five-byte frame, most significant bit first. It confirms that all forty bits arrived and that the fifth byte equals the low byte of the sum of the first four. It then converts the frame into temperature and humidity in tenths of a unit. One of two encodings is used, chosen by the `SENSOR_KIND` parameter. Each attempt ends with a one-cycle success or failure pulse. The result registers change only on success.

Top module: `hygro_reader`

## Requirements
- R1: After a strobe on `start_i` in idle, the block drives the line low (`line_oe_o`=1, `line_out_o`=0) for START_LOW_US microseconds, give or take one tick.
- R2: After the low interval, the block drives the line high (`line_oe_o`=1, `line_out_o`=1) for START_HIGH_US microseconds and then releases it. The output enable only ever falls out of the driven-high condition.
- R3: Once the line is released, the attempt ends with an error pulse if any single line level, including the wait for the sensor's first falling edge, lasts longer than TIMEOUT_US microseconds.
- R4: The first two falling edges after release are preamble and decode nothing. Each later falling edge ends one data bit: a preceding high phase longer than ONE_US microseconds is a 1, otherwise a 0. Bits fill byte 0 bit 7 first, through byte 4 bit 0.
- R5: A complete frame whose byte 4 differs from the low 8 bits of byte0+byte1+byte2+byte3 ends with an error pulse.
- R6: A frame cut short (fewer than 40 bits before a timeout) ends with an error pulse.
- R7: With SENSOR_KIND=0, `temp_o` = byte2×10 and `humid_o` = byte0×10.
- R8: With SENSOR_KIND=1, `humid_o` = {byte0,byte1}. `temp_o` is the two's-complement value of {byte2,byte3}, where bit 15 is a sign flag and bits 14:0 are the magnitude.
- R9: Each attempt produces exactly one pulse, either `valid_o` or `error_o` and never both. Each pulse is high for exactly one clock cycle.
- R10: `temp_o` and `humid_o` change only in the cycle where `valid_o` is high. After reset they are zero.
- R11: A strobe on `start_i` while an attempt is in progress has no effect.
- R12: `valid_o` rises on the third rising clock edge after the edge at which the final falling transition of `line_i` is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that begins a read |
| line_i | input | 1 | Level of the shared data line (asynchronous) |
| line_oe_o | output | 1 | Host drives the line when 1 |
| line_out_o | output | 1 | Level driven while `line_oe_o` is 1 |
| valid_o | output | 1 | One-cycle pulse: read succeeded, results updated |
| error_o | output | 1 | One-cycle pulse: read failed (timeout, short frame or checksum) |
| temp_o | output | 16 | Temperature in tenths, two's complement |
| humid_o | output | 16 | Relative humidity in tenths |

## Verification
The result pulse is due three rising edges after the edge that first samples the sensor's last falling transition. The bench records the cycle at which it drives that transition and the cycle at which the pulse appears, and it requires a difference of exactly four. Failure pulses are due one timeout interval after the last edge. The bench therefore waits a fixed margin beyond the timeout before it compares the pulse counts. Outputs are always sampled on the falling clock edge, and start-pulse lengths are measured in cycles against windows of one tick derived from the parameters.

// File: rtl/hygro_pkg.sv
package hygro_pkg;

  localparam int FRAME_BITS = 40;
  localparam int BIT_CNT_W  = $clog2(FRAME_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULL,
    ST_DRIVE,
    ST_LISTEN,
    ST_JUDGE
  } rd_state_t;

  // Received order: hum_hi arrives first (MSB of the frame)
  typedef struct packed {
    logic [7:0] hum_hi;
    logic [7:0] hum_lo;
    logic [7:0] tmp_hi;
    logic [7:0] tmp_lo;
    logic [7:0] check;
  } frame_t;

endpackage

// File: rtl/hygro_tick.sv
module hygro_tick #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;

  generate
    if (DIV == 1) begin : g_pass
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt_q, cnt_d;

      always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/hygro_phase.sv
// Line synchronizer, edge detector and per-level width timer.
module hygro_phase #(
  parameter int LIMIT = 101
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_i,
  input  logic                       tick_i,
  input  logic                       clear_i,
  output logic                       fall_o,
  output logic [$clog2(LIMIT+1)-1:0] width_o,
  output logic                       expired_o
);

  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic s1_q, s2_q, prev_q;
  logic [W-1:0] width_q, width_d;
  logic any_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign any_edge = s2_q ^ prev_q;
  assign fall_o   = prev_q & ~s2_q;

  always_comb begin
    width_d = width_q;
    if (clear_i || any_edge)           width_d = '0;
    else if (tick_i && width_q != LIM) width_d = width_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) width_q <= '0;
    else        width_q <= width_d;
  end

  assign width_o   = width_q;
  assign expired_o = (width_q == LIM);

endmodule

// File: rtl/hygro_collect.sv
module hygro_collect
  import hygro_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  take_i,
  input  logic                  bit_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic [BIT_CNT_W-1:0]  count_o
);

  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [BIT_CNT_W-1:0]  count_q, count_d;

  always_comb begin
    frame_d = frame_q;
    count_d = count_q;
    if (clear_i) begin
      frame_d = '0;
      count_d = '0;
    end else if (take_i) begin
      frame_d = {frame_q[FRAME_BITS-2:0], bit_i};
      count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      count_q <= '0;
    end else begin
      frame_q <= frame_d;
      count_q <= count_d;
    end
  end

  assign frame_o = frame_q;
  assign count_o = count_q;

endmodule

// File: rtl/hygro_convert.sv
module hygro_convert
  import hygro_pkg::*;
#(
  parameter int KIND = 0
) (
  input  frame_t      frame_i,
  output logic [15:0] temp_o,
  output logic [15:0] humid_o,
  output logic        sum_ok_o
);

  logic [9:0] total;

  assign total = {2'b00, frame_i.hum_hi} + {2'b00, frame_i.hum_lo}
               + {2'b00, frame_i.tmp_hi} + {2'b00, frame_i.tmp_lo};
  assign sum_ok_o = (total[7:0] == frame_i.check);

  generate
    if (KIND == 0) begin : g_whole
      logic unused_ok;
      assign unused_ok = ^{frame_i.hum_lo, frame_i.tmp_lo};
      assign temp_o  = {8'd0, frame_i.tmp_hi} * 16'd10;
      assign humid_o = {8'd0, frame_i.hum_hi} * 16'd10;
    end else begin : g_signed
      logic [15:0] mag;
      assign mag     = {1'b0, frame_i.tmp_hi[6:0], frame_i.tmp_lo};
      assign temp_o  = frame_i.tmp_hi[7] ? (16'd0 - mag) : mag;
      assign humid_o = {frame_i.hum_hi, frame_i.hum_lo};
    end
  endgenerate

endmodule

// File: rtl/hygro_reader.sv
module hygro_reader
  import hygro_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int SENSOR_KIND   = 0,
  parameter int START_LOW_US  = 18_000,
  parameter int START_HIGH_US = 30,
  parameter int TIMEOUT_US    = 100,
  parameter int ONE_US        = 35
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        line_i,
  output logic        line_oe_o,
  output logic        line_out_o,
  output logic        valid_o,
  output logic        error_o,
  output logic [15:0] temp_o,
  output logic [15:0] humid_o
);

  localparam int LIMIT = TIMEOUT_US + 1;
  localparam int TW    = $clog2(LIMIT + 1);
  localparam int CMAX  = (START_LOW_US > START_HIGH_US) ? START_LOW_US : START_HIGH_US;
  localparam int CW    = $clog2(CMAX + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(START_LOW_US - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(START_HIGH_US - 1);
  localparam logic [TW-1:0] ONE_THR   = TW'(ONE_US);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);
  localparam logic [BIT_CNT_W-1:0] ALL_BITS = BIT_CNT_W'(FRAME_BITS);

  // reset: asserted asynchronously, released on the clock
  logic rst_a_q, rst_b_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end
  assign rst_ni = rst_b_q;

  logic                  tick;
  logic                  fall, expired, tmr_clear;
  logic [TW-1:0]         width;
  logic                  take, col_clear;
  logic [FRAME_BITS-1:0] frame_bits;
  logic [BIT_CNT_W-1:0]  bits;
  logic [15:0]           conv_temp, conv_hum;
  logic                  sum_ok;

  hygro_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(1_000_000)) u_tick (
    .clk(clk), .rst_n(rst_ni), .tick_o(tick)
  );

  hygro_phase #(.LIMIT(LIMIT)) u_phase (
    .clk(clk), .rst_n(rst_ni), .line_i(line_i), .tick_i(tick),
    .clear_i(tmr_clear), .fall_o(fall), .width_o(width), .expired_o(expired)
  );

  hygro_collect u_collect (
    .clk(clk), .rst_n(rst_ni), .clear_i(col_clear), .take_i(take),
    .bit_i(width > ONE_THR), .frame_o(frame_bits), .count_o(bits)
  );

  hygro_convert #(.KIND(SENSOR_KIND)) u_convert (
    .frame_i(frame_t'(frame_bits)), .temp_o(conv_temp),
    .humid_o(conv_hum), .sum_ok_o(sum_ok)
  );

  rd_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    pre_q, pre_d;
  logic          valid_q, valid_d, error_q, error_d;
  logic [15:0]   temp_q, temp_d, hum_q, hum_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    pre_d      = pre_q;
    valid_d    = 1'b0;
    error_d    = 1'b0;
    temp_d     = temp_q;
    hum_d      = hum_q;
    line_oe_o  = 1'b0;
    line_out_o = 1'b0;
    take       = 1'b0;
    col_clear  = 1'b0;
    tmr_clear  = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_PULL;
          cnt_d     = '0;
          pre_d     = '0;
          col_clear = 1'b1;
        end
      end
      ST_PULL: begin
        line_oe_o = 1'b1;
        if (tick) begin
          if (cnt_q == LOW_LAST) begin
            state_d = ST_DRIVE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DRIVE: begin
        line_oe_o  = 1'b1;
        line_out_o = 1'b1;
        if (tick) begin
          if (cnt_q == HIGH_LAST) begin
            state_d = ST_LISTEN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_LISTEN: begin
        tmr_clear = 1'b0;
        if (expired) begin
          state_d = ST_JUDGE;
        end else if (fall) begin
          if (pre_q != 2'd2) begin
            pre_d = pre_q + 1'b1;
          end else begin
            take = 1'b1;
            if (bits == LAST_BIT) state_d = ST_JUDGE;
          end
        end
      end
      ST_JUDGE: begin
        state_d = ST_IDLE;
        if (bits == ALL_BITS && sum_ok) begin
          valid_d = 1'b1;
          temp_d  = conv_temp;
          hum_d   = conv_hum;
        end else begin
          error_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pre_q   <= '0;
      valid_q <= 1'b0;
      error_q <= 1'b0;
      temp_q  <= '0;
      hum_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pre_q   <= pre_d;
      valid_q <= valid_d;
      error_q <= error_d;
      temp_q  <= temp_d;
      hum_q   <= hum_d;
    end
  end

  assign valid_o = valid_q;
  assign error_o = error_q;
  assign temp_o  = temp_q;
  assign humid_o = hum_q;

endmodule

// File: rtl/hygro_reader_chk.sv
module hygro_reader_chk #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int START_LOW_US = 18_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        line_oe_o,
  input logic        line_out_o,
  input logic        valid_o,
  input logic        error_o,
  input logic [15:0] temp_o,
  input logic [15:0] humid_o
);

  localparam int DIV = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int MIN_LOW = (START_LOW_US - 1) * DIV;

  logic drive_low;
  int   low_len_q;

  assign drive_low = line_oe_o && !line_out_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_len_q <= 0;
    else if (drive_low) low_len_q <= low_len_q + 1;
    else                low_len_q <= 0;
  end

  a_r1_low_long_enough: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_low && $past(drive_low)) |-> (low_len_q > MIN_LOW));

  a_r2_release_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe_o) |-> $past(line_out_o));

  a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  a_r9_error_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> !error_o);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({valid_o, error_o}));

  a_r10_temp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(temp_o) |-> valid_o);

  a_r10_humid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(humid_o) |-> valid_o);

  a_r9_no_pulse_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe_o |-> !(valid_o || error_o));

endmodule

bind hygro_reader hygro_reader_chk #(
  .CLK_HZ(CLK_HZ),
  .START_LOW_US(START_LOW_US)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .line_oe_o(line_oe_o),
  .line_out_o(line_out_o),
  .valid_o(valid_o),
  .error_o(error_o),
  .temp_o(temp_o),
  .humid_o(humid_o)
);

// File: tb/sim_hygro_reader.sv
`timescale 1ns/1ps
module sim_hygro_reader;

  localparam int CLK_HZ = 2_000_000;
  localparam int DIV    = 2;
  localparam int LOW_US = 20;
  localparam int HIGH_US = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sens_low = 1'b0;
  logic line;
  logic oe0, out0, v0, e0, oe1, out1, v1, e1;
  logic [15:0] t0, h0, t1, h1;

  always #2.5 clk = ~clk;

  assign line = !((oe0 && !out0) || (oe1 && !out1) || sens_low);

  hygro_reader #(.CLK_HZ(CLK_HZ), .SENSOR_KIND(0), .START_LOW_US(LOW_US),
                 .START_HIGH_US(HIGH_US)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .line_i(line),
    .line_oe_o(oe0), .line_out_o(out0), .valid_o(v0), .error_o(e0),
    .temp_o(t0), .humid_o(h0));

  hygro_reader #(.CLK_HZ(CLK_HZ), .SENSOR_KIND(1), .START_LOW_US(LOW_US),
                 .START_HIGH_US(HIGH_US)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .line_i(line),
    .line_oe_o(oe1), .line_out_o(out1), .valid_o(v1), .error_o(e1),
    .temp_o(t1), .humid_o(h1));

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int nv0 = 0, ne0 = 0, nv1 = 0, ne1 = 0;
  int t_valid = 0;
  int t_fall = 0;
  int exp_t0 = 0, exp_h0 = 0, exp_t1 = 0, exp_h1 = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (v0) begin nv0 <= nv0 + 1; t_valid <= cyc; end
    if (e0) ne0 <= ne0 + 1;
    if (v1) nv1 <= nv1 + 1;
    if (e1) ne1 <= ne1 + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  // mode: 0 full frame, 1 stuck low in preamble; poke: strobe start mid-frame
  task automatic run_read(input logic [39:0] fr, input int nbits, input int mode,
                          input int w0, input int w1, input bit poke,
                          input bit measure);
    int b0v, b1v, b2v, b3v, b4v, sum, mag, tv;
    int snv0, sne0, snv1, sne1, len;
    bit good;
    snv0 = nv0; sne0 = ne0; snv1 = nv1; sne1 = ne1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!oe0) @(negedge clk);
    len = 0;
    while (oe0 && !out0) begin len++; @(negedge clk); end
    if (measure)
      check("R1 low interval in range", int'(len >= (LOW_US-1)*DIV+1 && len <= LOW_US*DIV+1), 1);
    len = 0;
    while (oe0 && out0) begin len++; @(negedge clk); end
    if (measure) begin
      check("R2 high interval in range", int'(len >= (HIGH_US-1)*DIV && len <= HIGH_US*DIV+1), 1);
      check("R2 line released", int'(oe0), 0);
    end
    wait_us(20);
    if (mode == 1) begin
      sens_low = 1'b1; wait_us(150); sens_low = 1'b0;
    end else begin
      sens_low = 1'b1; wait_us(80);
      sens_low = 1'b0; wait_us(80);
      for (int b = 0; b < nbits; b++) begin
        sens_low = 1'b1; wait_us(50);
        sens_low = 1'b0;
        if (poke && b == 10) begin
          start = 1'b1; @(negedge clk); start = 1'b0;
        end
        wait_us(fr[39-b] ? w1 : w0);
      end
      sens_low = 1'b1;
      t_fall = cyc;
      wait_us(50);
      sens_low = 1'b0;
    end
    wait_us(160);
    b0v = int'(fr[39:32]); b1v = int'(fr[31:24]); b2v = int'(fr[23:16]);
    b3v = int'(fr[15:8]);  b4v = int'(fr[7:0]);
    sum = (b0v + b1v + b2v + b3v) % 256;
    good = (mode == 0) && (nbits == 40) && (sum == b4v);
    if (good) begin
      exp_t0 = b2v * 10; exp_h0 = b0v * 10;
      mag = (b2v % 128) * 256 + b3v;
      tv = (b2v >= 128) ? -mag : mag;
      exp_t1 = tv & 16'hFFFF;
      exp_h1 = b0v * 256 + b1v;
      check("R9 one valid pulse kind0", nv0 - snv0, 1);
      check("R9 no error pulse kind0", ne0 - sne0, 0);
      check("R9 one valid pulse kind1", nv1 - snv1, 1);
      check("R12 result latency", t_valid - t_fall, 4);
    end else begin
      check("R3/R5/R6 one error pulse kind0", ne0 - sne0, 1);
      check("R9 no valid pulse on failure", nv0 - snv0, 0);
      check("R5/R6 one error pulse kind1", ne1 - sne1, 1);
    end
    check("R7 temperature kind0", int'(t0), exp_t0);
    check("R7 humidity kind0", int'(h0), exp_h0);
    check("R8 temperature kind1", int'(t1), exp_t1);
    check("R8 humidity kind1", int'(h1), exp_h1);
  endtask

  function automatic logic [39:0] mkframe(input int a, input int b, input int c,
                                          input int d, input int bad);
    logic [7:0] s;
    s = 8'(a + b + c + d) ^ 8'(bad);
    return {8'(a), 8'(b), 8'(c), 8'(d), s};
  endfunction

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("reset line released", int'(oe0), 0);
    check("R10 reset temperature", int'(t0), 0);
    check("R10 reset humidity", int'(h1), 0);
    check("R9 reset no pulses", int'(v0 | e0 | v1 | e1), 0);

    // sweep of byte patterns and pulse widths (R4, R7, R8, R11 on k==1)
    for (int k = 0; k < 6; k++) begin
      run_read(mkframe((k*53+7)%256, (k*29+3)%256, (k*71+11)%256,
                       (k*17+200)%256, 0),
               40, 0, 10 + k*3, 45 + k*5, (k == 1), (k == 0));
    end
    // negative temperature for the signed kind (R8)
    run_read(mkframe(2, 140, 8'h80, 8'h65, 0), 40, 0, 24, 70, 1'b0, 1'b0);
    // checksum mismatch (R5), results held (R10)
    run_read(mkframe(50, 1, 20, 2, 1), 40, 0, 24, 70, 1'b0, 1'b0);
    // frame cut short (R6, R3)
    run_read(mkframe(9, 9, 9, 9, 0), 20, 0, 24, 70, 1'b0, 1'b0);
    // level held too long in the preamble (R3)
    run_read(mkframe(0, 0, 0, 0, 0), 0, 1, 24, 70, 1'b0, 1'b0);
    // a good read still follows the failures
    run_read(mkframe(61, 0, 24, 5, 0), 40, 0, 26, 50, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule